// File: doc/BRIEF.md
# Indexed Multi-Sub-Array Stream Register Bank

This block is one lane's bank of a stream register file. The storage is split into four sub-arrays. Each sub-array has its own row decoder and a word-select mux on its output. The bank serves two kinds of traffic:

- **Sequential access.** A block-wide port reads or writes four contiguous 32-bit words. All four words sit in one row of one sub-array.
- **Indexed reads.** Single-word read addresses are pushed into a small in-order queue. In each cycle the bank serves at most one queued word from each sub-array, so up to four words per cycle.

Indexed results go back to the compute lane through a separate data port, in the order the addresses were pushed. Issuing an address and collecting its data are separate operations, and any number of cycles may pass between them. A collect request for data that is not yet available raises a stall, and the bank does not hand over stale data. A sequential access wins its cycle: it blocks indexed service in all sub-arrays for that cycle.

Top module: `srfb_bank`

## Requirements
- R1: During reset and on the first clock after it, the queue is empty, `idx_ready` is 1, `seq_rdata` is 0, and `data_stall` is 1 whenever `data_rd` is 1.
- R2: A 7-bit indexed word address splits into fields as follows:
  - bits [1:0] select the sub-array,
  - bits [4:2] select the mux position within the row,
  - bits [6:5] select the row.
- R3: A sequential write (`seq_en`=1, `seq_we`=1) with block address `b` stores word k (bits [32k+31:32k] of `seq_wdata`) at word address {`b[4:3]`, `b[2]`, k[1:0], `b[1:0]`}. All four words therefore land in one row of sub-array `b[1:0]`, and the write takes effect at that clock edge.
- R4: A sequential read (`seq_en`=1, `seq_we`=0) presents the block on `seq_rdata` after the same clock edge, using the word packing of R3. `seq_rdata` holds its value until the next sequential read.
- R5: Indexed data leaves on `data_out` in push order. While `data_rd`=1 and `data_stall`=0, `data_out` carries the oldest queued result, and that entry is retired at the clock edge.
- R6: In one cycle with `seq_en`=0, every sub-array that has a pending queued address serves one of them. Four pending reads to four different sub-arrays therefore all complete on a single clock edge.
- R7: When several pending reads map to the same sub-array, the oldest one is served first, and the rest wait for later cycles.
- R8: A cycle with `seq_en`=1 serves no indexed read.
- R9: `data_stall` is 1 when `data_rd`=1 and the oldest entry is missing or not yet served. A stalled request retires nothing.
- R10: The queue holds 8 entries. When it is full, `idx_ready` is 0 and an address offered on `idx_valid` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seq_en | input | 1 | Sequential block access this cycle |
| seq_we | input | 1 | 1 = sequential write, 0 = sequential read |
| seq_addr | input | 5 | Block address: {row, half, sub-array} |
| seq_wdata | input | 128 | Block write data, word k at bits [32k+31:32k] |
| seq_rdata | output | 128 | Registered block read data |
| idx_valid | input | 1 | Indexed read address offered |
| idx_addr | input | 7 | Indexed word address |
| idx_ready | output | 1 | Queue can accept an address |
| data_rd | input | 1 | Lane requests the next indexed result |
| data_out | output | 32 | Oldest indexed result |
| data_stall | output | 1 | Requested result not yet available |

## Verification
Timing of results:

- A pushed address becomes eligible on the clock edge after the push.
- With no sequential access and no conflict, its word is on `data_out` right after that edge. That is two edges from the push, with `data_rd` and `data_stall` combinational in the same cycle.
- Sequential read data appears one edge after `seq_en`.

The bench drives inputs on the falling edge and samples one time step later. It uses sequential accesses to freeze indexed service for an exact number of cycles. As a result, it knows on each edge which queued entries have been served, and it expects a stall or a data word exactly there.

// File: rtl/srfb_pkg.sv
// Shared types for the indexed stream register bank.
package srfb_pkg;
    // Life cycle of one indexed-read queue entry.
    typedef enum logic [1:0] {
        E_FREE = 2'd0,
        E_PEND = 2'd1,
        E_DONE = 2'd2
    } ent_state_t;
endpackage

// File: rtl/srfb_subarray.sv
// One storage sub-array: ROWS rows of WPR words, with one block-wide
// write/read port (BLK contiguous words of a row) and one single-word
// read port through a WPR:1 word-select mux.
// Assumes: the block port and the word port are never used for
// conflicting purposes in one cycle (the bank guarantees this).
module srfb_subarray #(
    parameter int W    = 32,
    parameter int WPR  = 8,
    parameter int ROWS = 4,
    parameter int BLK  = 4,
    localparam int MW  = $clog2(WPR),
    localparam int RW  = $clog2(ROWS),
    localparam int BW  = $clog2(BLK),
    localparam int HW  = MW - BW
) (
    input  logic             clk,
    input  logic             we,
    input  logic [RW-1:0]    blk_row,
    input  logic [HW-1:0]    blk_half,
    input  logic [BLK*W-1:0] wdata,
    output logic [BLK*W-1:0] blk_rdata,
    input  logic [RW-1:0]    rd_row,
    input  logic [MW-1:0]    rd_mux,
    output logic [W-1:0]     rd_word
);
    logic [W-1:0] mem [ROWS][WPR];

    // Block write of BLK contiguous words into one row.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int k = 0; k < BLK; k++) begin
                mem[blk_row][{blk_half, BW'(k)}] <= wdata[k*W +: W];
            end
        end
    end

    // Block read of the addressed half-row.
    always_comb begin
        for (int k = 0; k < BLK; k++) begin
            blk_rdata[k*W +: W] = mem[blk_row][{blk_half, BW'(k)}];
        end
    end

    // Single-word read through the word-select mux.
    assign rd_word = mem[rd_row][rd_mux];
endmodule

// File: rtl/srfb_arbiter.sv
// Per-sub-array conflict arbiter. For every sub-array it picks the oldest
// pending queue entry (counting from head) whose address maps to it.
// Assumes: Q is a power of two so queue indices wrap naturally.
module srfb_arbiter #(
    parameter int NSUB = 4,
    parameter int Q    = 8,
    localparam int SW  = $clog2(NSUB),
    localparam int QW  = $clog2(Q)
) (
    input  logic [QW-1:0]             head,
    input  logic [Q-1:0]              pend,
    input  logic [Q-1:0][SW-1:0]      subs,
    output logic [NSUB-1:0]           sel_vld,
    output logic [NSUB-1:0][QW-1:0]   sel_idx
);
    for (genvar s = 0; s < NSUB; s++) begin : g_pick
        logic          v;
        logic [QW-1:0] ix;
        // Scan youngest to oldest so the oldest match is the last written.
        always_comb begin
            v  = 1'b0;
            ix = '0;
            for (int k = Q - 1; k >= 0; k--) begin
                if (pend[head + QW'(k)] && subs[head + QW'(k)] == SW'(s)) begin
                    v  = 1'b1;
                    ix = head + QW'(k);
                end
            end
        end
        assign sel_vld[s] = v;
        assign sel_idx[s] = ix;
    end
endmodule

// File: rtl/srfb_bank.sv
// Indexed multi-sub-array stream register bank (top).
// Sequential block port plus an in-order indexed-read queue. Each cycle
// without a sequential access, each sub-array serves its oldest pending
// indexed read; results retire in push order through data_out.
// Assumes: indexed traffic is read-only; Q is a power of two.
module srfb_bank
    import srfb_pkg::*;
#(
    parameter int W    = 32,
    parameter int NSUB = 4,
    parameter int WPR  = 8,
    parameter int ROWS = 4,
    parameter int BLK  = 4,
    parameter int Q    = 8,
    localparam int SW  = $clog2(NSUB),
    localparam int MW  = $clog2(WPR),
    localparam int RW  = $clog2(ROWS),
    localparam int BW  = $clog2(BLK),
    localparam int HW  = MW - BW,
    localparam int AW  = SW + MW + RW,
    localparam int BAW = SW + HW + RW,
    localparam int QW  = $clog2(Q)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seq_en,
    input  logic             seq_we,
    input  logic [BAW-1:0]   seq_addr,
    input  logic [BLK*W-1:0] seq_wdata,
    output logic [BLK*W-1:0] seq_rdata,
    input  logic             idx_valid,
    input  logic [AW-1:0]    idx_addr,
    output logic             idx_ready,
    input  logic             data_rd,
    output logic [W-1:0]     data_out,
    output logic             data_stall
);
    ent_state_t     st       [Q];
    logic [AW-1:0]  ent_addr [Q];
    logic [W-1:0]   ent_data [Q];
    logic [QW-1:0]  head, tail;
    logic [QW:0]    cnt;

    logic [Q-1:0]            pend;
    logic [Q-1:0][SW-1:0]    subs;
    logic [NSUB-1:0]         sel_vld;
    logic [NSUB-1:0][QW-1:0] sel_idx;
    logic [W-1:0]            sub_word [NSUB];
    logic [BLK*W-1:0]        sub_blk  [NSUB];
    logic                    push, pop;

    wire [SW-1:0] seq_sub  = seq_addr[SW-1:0];
    wire [HW-1:0] seq_half = seq_addr[SW +: HW];
    wire [RW-1:0] seq_row  = seq_addr[SW+HW +: RW];

    // Handshake and retire conditions of the queue.
    assign idx_ready  = (cnt != (QW+1)'(Q));
    assign push       = idx_valid && idx_ready;
    assign data_stall = data_rd && ((cnt == '0) || (st[head] != E_DONE));
    assign pop        = data_rd && !data_stall;
    assign data_out   = ent_data[head];

    // Arbiter inputs: pending flags and target sub-array of each entry.
    always_comb begin
        for (int i = 0; i < Q; i++) begin
            pend[i] = (st[i] == E_PEND);
            subs[i] = ent_addr[i][SW-1:0];
        end
    end

    srfb_arbiter #(.NSUB(NSUB), .Q(Q)) u_arb (
        .head    (head),
        .pend    (pend),
        .subs    (subs),
        .sel_vld (sel_vld),
        .sel_idx (sel_idx)
    );

    for (genvar s = 0; s < NSUB; s++) begin : g_sub
        srfb_subarray #(.W(W), .WPR(WPR), .ROWS(ROWS), .BLK(BLK)) u_sa (
            .clk       (clk),
            .we        (seq_en && seq_we && (seq_sub == SW'(s))),
            .blk_row   (seq_row),
            .blk_half  (seq_half),
            .wdata     (seq_wdata),
            .blk_rdata (sub_blk[s]),
            .rd_row    (ent_addr[sel_idx[s]][SW+MW +: RW]),
            .rd_mux    (ent_addr[sel_idx[s]][SW +: MW]),
            .rd_word   (sub_word[s])
        );
    end

    // Queue control: allocate on push, complete on service, free on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
            cnt  <= '0;
            for (int i = 0; i < Q; i++) st[i] <= E_FREE;
        end else begin
            if (push) begin
                st[tail] <= E_PEND;
                tail     <= tail + 1'b1;
            end
            if (!seq_en) begin
                for (int s = 0; s < NSUB; s++) begin
                    if (sel_vld[s]) st[sel_idx[s]] <= E_DONE;
                end
            end
            if (pop) begin
                st[head] <= E_FREE;
                head     <= head + 1'b1;
            end
            cnt <= cnt + (QW+1)'(push) - (QW+1)'(pop);
        end
    end

    // Entry payload: address on push, read word on service.
    always_ff @(posedge clk) begin
        if (push) ent_addr[tail] <= idx_addr;
        if (!seq_en) begin
            for (int s = 0; s < NSUB; s++) begin
                if (sel_vld[s]) ent_data[sel_idx[s]] <= sub_word[s];
            end
        end
    end

    // Registered sequential read data.
    always_ff @(posedge clk) begin
        if (!rst_n)                 seq_rdata <= '0;
        else if (seq_en && !seq_we) seq_rdata <= sub_blk[seq_sub];
    end

    // Count of completed entries, used by the priority check.
    logic [QW:0] ndone;
    always_comb begin
        ndone = '0;
        for (int i = 0; i < Q; i++) ndone = ndone + (QW+1)'(st[i] == E_DONE);
    end

    // R8: a sequential cycle completes no indexed read.
    a_r8_seq_blocks_index: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_en && !pop) |=> (ndone == $past(ndone)));

    // R9: a stalled request retires nothing.
    a_r9_stall_holds_head: assert property (@(posedge clk) disable iff (!rst_n)
        data_stall |=> (head == $past(head)));

    // R10: a full queue accepts no address.
    a_r10_full_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_ready) |=> (tail == $past(tail)));

    // R5: an unstalled request retires exactly the head entry.
    a_r5_pop_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !data_stall) |=> (head == QW'($past(head) + 1'b1)));

    // R7: each grant points at a pending entry of that sub-array.
    for (genvar s = 0; s < NSUB; s++) begin : g_chk
        a_r7_grant_matches: assert property (@(posedge clk) disable iff (!rst_n)
            sel_vld[s] |-> ((st[sel_idx[s]] == E_PEND) &&
                            (ent_addr[sel_idx[s]][SW-1:0] == SW'(s))));
    end
endmodule

// File: tb/srfb_bank_bench.sv
// Directed bench for srfb_bank: one task per scenario.
module srfb_bank_bench;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         seq_en, seq_we;
    logic [4:0]   seq_addr;
    logic [127:0] seq_wdata;
    logic [127:0] seq_rdata;
    logic         idx_valid;
    logic [6:0]   idx_addr;
    logic         idx_ready;
    logic         data_rd;
    logic [31:0]  data_out;
    logic         data_stall;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    srfb_bank u_srfb_bank (
        .clk(clk), .rst_n(rst_n), .seq_en(seq_en), .seq_we(seq_we),
        .seq_addr(seq_addr), .seq_wdata(seq_wdata), .seq_rdata(seq_rdata),
        .idx_valid(idx_valid), .idx_addr(idx_addr), .idx_ready(idx_ready),
        .data_rd(data_rd), .data_out(data_out), .data_stall(data_stall)
    );

    function automatic logic [31:0] wv(int a);
        return 32'h5A00_0000 + 32'(a) * 32'h0001_0003;
    endfunction

    // Word address of word k of block b (R3 mapping).
    function automatic int wa(int b, int k);
        return ((b >> 3) << 5) | ((((b >> 2) & 1) * 4 + k) << 2) | (b & 3);
    endfunction

    function automatic logic [127:0] blk_val(int b);
        logic [127:0] v;
        for (int k = 0; k < 4; k++) v[k*32 +: 32] = wv(wa(b, k));
        return v;
    endfunction

    task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_addr(int a);
        @(negedge clk);
        idx_valid = 1'b1;
        idx_addr  = 7'(a);
        @(posedge clk);
        @(negedge clk);
        idx_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; seq_en = 0; seq_we = 0; seq_addr = '0; seq_wdata = '0;
        idx_valid = 0; idx_addr = '0; data_rd = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        data_rd = 1'b1;
        #1;
        chk(idx_ready == 1'b1, "R1 ready", 128'(idx_ready), 128'd1);
        chk(seq_rdata == '0, "R1 seq_rdata", seq_rdata, '0);
        chk(data_stall == 1'b1, "R1 R9 empty stall", 128'(data_stall), 128'd1);
        data_rd = 1'b0;
    endtask

    task automatic t_fill;
        for (int b = 0; b < 32; b++) begin
            @(negedge clk);
            seq_en = 1; seq_we = 1; seq_addr = 5'(b); seq_wdata = blk_val(b);
        end
        @(negedge clk);
        seq_en = 0; seq_we = 0;
    endtask

    task automatic t_seq_read;
        int blks[3] = '{5, 22, 31};
        foreach (blks[i]) begin
            @(negedge clk);
            seq_en = 1; seq_we = 0; seq_addr = 5'(blks[i]);
            @(negedge clk);
            seq_en = 0;
            #1;
            chk(seq_rdata == blk_val(blks[i]), "R3 R4 block read", seq_rdata, blk_val(blks[i]));
        end
        @(negedge clk);
        #1;
        chk(seq_rdata == blk_val(31), "R4 hold", seq_rdata, blk_val(31));
    endtask

    // Four distinct sub-arrays complete in one unblocked cycle.
    task automatic t_parallel;
        int a[4] = '{36, 125, 10, 87};
        @(negedge clk);
        seq_en = 1; seq_we = 0; seq_addr = '0;
        foreach (a[i]) push_addr(a[i]);
        seq_en = 0;             // one unblocked cycle
        @(negedge clk);
        seq_en = 1; data_rd = 1;
        foreach (a[i]) begin
            #1;
            chk(data_stall == 1'b0, "R6 served together", 128'(data_stall), 128'd0);
            chk(data_out == wv(a[i]), "R2 R5 R6 data order", 128'(data_out), 128'(wv(a[i])));
            @(negedge clk);
        end
        data_rd = 0; seq_en = 0;
    endtask

    // Same sub-array conflict, sequential priority and stall.
    task automatic t_conflict;
        int a0 = 36, a1 = 12, b = 33, c = 122;
        @(negedge clk);
        seq_en = 1; seq_we = 0; seq_addr = 5'd3;
        push_addr(a0); push_addr(a1); push_addr(b); push_addr(c);
        data_rd = 1;
        #1;
        chk(data_stall == 1'b1, "R8 R9 blocked stall", 128'(data_stall), 128'd1);
        @(negedge clk);
        seq_en = 0; data_rd = 0;     // one unblocked cycle
        @(negedge clk);
        seq_en = 1; data_rd = 1;
        #1;
        chk(data_stall == 1'b0 && data_out == wv(a0), "R7 oldest first",
            128'(data_out), 128'(wv(a0)));
        @(negedge clk);
        #1;
        chk(data_stall == 1'b1, "R7 R9 younger waits", 128'(data_stall), 128'd1);
        @(negedge clk);
        #1;
        chk(data_stall == 1'b1, "R8 still blocked", 128'(data_stall), 128'd1);
        seq_en = 0;
        @(negedge clk);
        seq_en = 1;
        #1;
        chk(data_stall == 1'b0 && data_out == wv(a1), "R7 second served",
            128'(data_out), 128'(wv(a1)));
        @(negedge clk);
        #1;
        chk(data_stall == 1'b0 && data_out == wv(b), "R5 R6 order b",
            128'(data_out), 128'(wv(b)));
        @(negedge clk);
        #1;
        chk(data_stall == 1'b0 && data_out == wv(c), "R5 R6 order c",
            128'(data_out), 128'(wv(c)));
        @(negedge clk);
        data_rd = 0; seq_en = 0;
    endtask

    // Full queue drops an extra address.
    task automatic t_full;
        @(negedge clk);
        seq_en = 1; seq_we = 0; seq_addr = '0;
        for (int i = 0; i < 8; i++) push_addr(i * 9);
        #1;
        chk(idx_ready == 1'b0, "R10 full", 128'(idx_ready), 128'd0);
        push_addr(1);           // must be dropped
        seq_en = 0;
        repeat (3) @(negedge clk);
        data_rd = 1;
        for (int i = 0; i < 8; i++) begin
            #1;
            chk(data_stall == 1'b0 && data_out == wv(i * 9), "R10 R5 drain",
                128'(data_out), 128'(wv(i * 9)));
            @(negedge clk);
        end
        #1;
        chk(data_stall == 1'b1, "R10 R9 extra dropped", 128'(data_stall), 128'd1);
        chk(idx_ready == 1'b1, "R10 ready again", 128'(idx_ready), 128'd1);
        data_rd = 0;
    endtask

    initial begin
        t_reset();
        t_fill();
        t_seq_read();
        t_parallel();
        t_conflict();
        t_full();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule